// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between an internal request port and an external asynchronous static RAM that holds 512K words of 16 bits, with a 19-bit word address. The data bus is split into a lower lane (bits 7:0) and an upper lane (bits 15:8), and each lane has its own active-low select. The requester presents one read or one write at a time on a valid/ready handshake. Each request carries an address, write data and a two-bit lane enable. The controller then sequences the memory strobes: an active-low chip select, an active-high chip select, output enable, write enable and the two lane selects. It drives the shared tri-state data bus during writes and returns read data with a one-cycle valid pulse.

The access is run by a state machine with six states. ST_IDLE waits for a request. ST_SETUP presents the address and selects the chip while write enable and output enable stay high. ST_WPULSE holds write enable low and drives the bus. ST_RPULSE holds output enable low and lets the memory drive the bus. ST_RECOVER raises the active pulse strobe while the address, selects and write data are still held, and then returns to idle. ST_SKIP takes one cycle and completes a request whose lane enable is zero.

The transitions are:
- IDLE→SETUP on acceptance with a nonzero lane enable.
- IDLE→SKIP on acceptance with a zero lane enable.
- SETUP→WPULSE for a write and SETUP→RPULSE for a read.
- WPULSE→RECOVER and RPULSE→RECOVER when the wait timer expires.
- RECOVER→IDLE and SKIP→IDLE unconditionally.

The pulse length is WAIT_CYC = ceil(ACCESS_NS / CLK_NS) clock cycles. With the defaults this is 7 cycles, which covers a 70 ns access at a 100 MHz clock.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and in idle, the strobes are inactive: `mem_cs_n`=1, `mem_cs`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_ub_n`=`mem_lb_n`=1. In the same state `req_ready`=1 and `rsp_valid`=0.
- R2: Lane enable bit 1 maps to the upper lane (data bits 15:8, `mem_ub_n`) and bit 0 to the lower lane (bits 7:0, `mem_lb_n`). With enable 2'b11, a written word reads back whole, and `mem_addr` carries the full 19-bit request address.
- R3: A write with one lane enabled asserts only that lane's select and leaves the other byte of the stored word unchanged. That select is low for WAIT_CYC+2 cycles.
- R4: A read with one lane enabled asserts only that lane's select. It returns that byte in its lane, with the other lane's bits forced to zero.
- R5: In a write, `mem_we_n` is low for exactly WAIT_CYC consecutive cycles. Throughout that time both chip selects are asserted, at least one lane select is low and `mem_oe_n` stays high.
- R6: The address is stable and the chip is selected for at least one cycle before `mem_we_n` falls. The write ends with `mem_we_n` rising first, while the chip selects, lane selects and address are held for one more recovery cycle.
- R7: In a read, `mem_oe_n` is low for exactly WAIT_CYC cycles while `mem_we_n` stays high. The controller never drives the bus while `mem_oe_n` is low, and it releases the bus at least one cycle before `mem_oe_n` falls.
- R8: After acceptance, `req_ready` stays low for WAIT_CYC+2 cycles. A read gives exactly one `rsp_valid` pulse, in the recovery cycle, and a write gives none.
- R9: A request with lane enable 2'b00 asserts no memory strobe, holds `req_ready` low for one cycle and leaves memory unchanged. If it is a read, it returns one `rsp_valid` pulse with data zero.
- R10: WAIT_CYC is ceil(ACCESS_NS/CLK_NS), which gives 7 cycles with the defaults (70, 10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enable, bit 1 upper, bit 0 lower |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 19 | Memory address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_dq | inout | 16 | Shared data bus |

## Verification
The bench watches the strobe timing:
- The number of cycles with write enable low and with output enable low. A timer that is off by one shows up as WAIT_CYC±1.
- Whether the address and chip selects surround the write pulse. A design that dropped the setup or recovery cycle would show write enable moving in the same cycle as the select or the address.

Single-lane writes are read back as whole words. A design that swapped the lane mapping, or selected both lanes, would corrupt the neighbouring byte. Single-lane reads must return zero in the disabled lane.

Zero-enable requests must complete in one cycle with no strobe at all. A design that treated them as normal accesses would pulse the chip selects and take the full WAIT_CYC+2 cycles.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_WPULSE  = 3'd2,
        ST_RPULSE  = 3'd3,
        ST_RECOVER = 3'd4,
        ST_SKIP    = 3'd5
    } lane_state_e;

    typedef struct packed {
        logic cs_n;
        logic cs;
        logic oe_n;
        logic we_n;
        logic ub_n;
        logic lb_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBE_OFF = '{cs_n: 1'b1, cs: 1'b0, oe_n: 1'b1, we_n: 1'b1,
                                       ub_n: 1'b1, lb_n: 1'b1, drive: 1'b0};

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int unsigned WAIT_CYC = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int unsigned CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(WAIT_CYC - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_dq_port.sv
module sram_dq_port #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drive,
    input  logic [DATA_W-1:0] wdata,
    input  logic              capture,
    input  logic              clear,
    input  logic [1:0]        lane_en,
    inout  wire  [DATA_W-1:0] dq,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned LANE_W = DATA_W / 2;

    logic [1:0][LANE_W-1:0] lane_q;

    assign dq    = drive ? wdata : {DATA_W{1'bz}};
    assign rdata = lane_q;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q[g] <= '0;
            end else if (clear) begin
                lane_q[g] <= '0;
            end else if (capture) begin
                lane_q[g] <= lane_en[g] ? dq[g*LANE_W +: LANE_W] : '0;
            end
        end
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int unsigned ADDR_W    = 19,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CLK_NS    = 10,
    parameter int unsigned ACCESS_NS = 70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    inout  wire  [DATA_W-1:0] mem_dq
);
    localparam int unsigned WAIT_CYC = ceil_div(ACCESS_NS, CLK_NS);

    lane_state_e       state_q, state_nxt;
    logic              wr_q;
    logic [1:0]        be_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    strobe_t           strb_q, strb_d;
    logic              rsp_q;
    logic              accept, zero_be, t_start, t_done, capture;
    logic              wr_nx;
    logic [1:0]        be_nx;
    logic              bus_drive;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign zero_be   = (req_be == 2'b00);
    assign t_start   = (state_q == ST_SETUP);
    assign capture   = (state_q == ST_RPULSE) && t_done;

    sram_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (t_start),
        .done  (t_done)
    );

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_nxt = zero_be ? ST_SKIP : ST_SETUP;
            ST_SETUP:   state_nxt = wr_q ? ST_WPULSE : ST_RPULSE;
            ST_WPULSE:  if (t_done) state_nxt = ST_RECOVER;
            ST_RPULSE:  if (t_done) state_nxt = ST_RECOVER;
            ST_RECOVER: state_nxt = ST_IDLE;
            ST_SKIP:    state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
            be_q    <= 2'b00;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_nxt;
            if (accept) begin
                wr_q    <= req_write;
                be_q    <= req_be;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    // strobe decode from the upcoming state, registered so the pins never glitch
    always_comb begin
        wr_nx  = accept ? req_write : wr_q;
        be_nx  = accept ? req_be    : be_q;
        strb_d = STROBE_OFF;
        unique case (state_nxt)
            ST_SETUP, ST_RECOVER, ST_WPULSE, ST_RPULSE: begin
                strb_d.cs_n = 1'b0;
                strb_d.cs   = 1'b1;
                strb_d.ub_n = !be_nx[1];
                strb_d.lb_n = !be_nx[0];
                if (state_nxt == ST_WPULSE) begin
                    strb_d.we_n  = 1'b0;
                    strb_d.drive = 1'b1;
                end
                if (state_nxt == ST_RPULSE) begin
                    strb_d.oe_n = 1'b0;
                end
                if (state_nxt == ST_RECOVER && wr_nx) begin
                    strb_d.drive = 1'b1;
                end
            end
            ST_IDLE, ST_SKIP: strb_d = STROBE_OFF;
            default:          strb_d = STROBE_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb_q <= STROBE_OFF;
            rsp_q  <= 1'b0;
        end else begin
            strb_q <= strb_d;
            rsp_q  <= capture || (accept && zero_be && !req_write);
        end
    end

    assign mem_cs_n  = strb_q.cs_n;
    assign mem_cs    = strb_q.cs;
    assign mem_oe_n  = strb_q.oe_n;
    assign mem_we_n  = strb_q.we_n;
    assign mem_ub_n  = strb_q.ub_n;
    assign mem_lb_n  = strb_q.lb_n;
    assign bus_drive = strb_q.drive;
    assign mem_addr  = addr_q;
    assign rsp_valid = rsp_q;

    sram_dq_port #(.DATA_W(DATA_W)) u_dq (
        .clk     (clk),
        .rst_n   (rst_n),
        .drive   (bus_drive),
        .wdata   (wdata_q),
        .capture (capture),
        .clear   (accept && zero_be),
        .lane_en (be_q),
        .dq      (mem_dq),
        .rdata   (rsp_rdata)
    );

endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
    parameter int unsigned ADDR_W   = 19,
    parameter int unsigned WAIT_CYC = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_cs,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_ub_n,
    input logic              mem_lb_n,
    input logic              drive
);
    logic [15:0] we_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         we_run <= '0;
        else if (!mem_we_n) we_run <= we_run + 16'd1;
        else                we_run <= '0;
    end

    // R7
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R5
    we_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_cs && !(mem_ub_n && mem_lb_n)));

    // R5
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run == 16'(WAIT_CYC)));

    // R6
    we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($stable(mem_addr) && !$past(mem_cs_n)));

    // R6
    we_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_cs_n && mem_cs && $stable(mem_addr)));

    // R7
    rd_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !drive);

    // R7
    drive_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(drive));

    // R8
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !req_ready);

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

bind sram_lane_ctrl sram_lane_chk #(.ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_cs    (mem_cs),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_ub_n  (mem_ub_n),
    .mem_lb_n  (mem_lb_n),
    .drive     (bus_drive)
);

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;
    localparam int ADDR_W   = 19;
    localparam int DATA_W   = 16;
    localparam int EXP_WAIT = (70 + 10 - 1) / 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [1:0]        req_be = 2'b00;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic [ADDR_W-1:0] mem_addr;
    logic mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
    wire  [DATA_W-1:0] mem_dq;

    sram_lane_ctrl u_sram_lane_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq(mem_dq)
    );

    // behavioural memory, 256 words indexed by the low address bits
    logic [15:0] sram [0:255];
    wire  [7:0]  widx = mem_addr[7:0];
    wire  m_sel  = !mem_cs_n && mem_cs && !(mem_ub_n && mem_lb_n);
    wire  m_read = m_sel && mem_we_n && !mem_oe_n;
    assign mem_dq[7:0]  = (m_read && !mem_lb_n) ? sram[widx][7:0]  : 8'bz;
    assign mem_dq[15:8] = (m_read && !mem_ub_n) ? sram[widx][15:8] : 8'bz;

    function automatic logic [15:0] init_word(input int i);
        return {~8'(i), 8'(i)};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) sram[i] <= init_word(i);
        end else if (m_sel && !mem_we_n) begin
            if (!mem_lb_n) sram[widx][7:0]  <= mem_dq[7:0];
            if (!mem_ub_n) sram[widx][15:8] <= mem_dq[15:8];
        end
    end

    // cumulative monitor, sampled at the falling edge
    int we_low_n = 0, oe_low_n = 0, ub_low_n = 0, lb_low_n = 0, any_n = 0;
    int rdy_low_n = 0, rsp_n = 0, bad_n = 0;
    logic [15:0]       last_rd = '0;
    logic [ADDR_W-1:0] last_sel_addr = '0;
    logic              prev_we_n = 1'b1, prev_sel = 1'b0;
    logic [ADDR_W-1:0] prev_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n) we_low_n++;
            if (!mem_oe_n) oe_low_n++;
            if (!mem_ub_n) ub_low_n++;
            if (!mem_lb_n) lb_low_n++;
            if (!mem_cs_n || mem_cs || !mem_oe_n || !mem_we_n || !mem_ub_n || !mem_lb_n) any_n++;
            if (!req_ready) rdy_low_n++;
            if (rsp_valid) begin rsp_n++; last_rd = rsp_rdata; end
            if (m_sel) last_sel_addr = mem_addr;
            if (!mem_we_n && !mem_oe_n) bad_n++;
            if (!mem_we_n && prev_we_n && !(prev_sel && prev_addr == mem_addr)) bad_n++;
            if (mem_we_n && !prev_we_n && !(m_sel && prev_addr == mem_addr)) bad_n++;
            prev_we_n = mem_we_n;
            prev_sel  = !mem_cs_n && mem_cs;
            prev_addr = mem_addr;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [15:0] exp_mem [0:255];
    int dl_we, dl_oe, dl_ub, dl_lb, dl_any, dl_rdy, dl_rsp, dl_bad;
    logic [15:0] rd_val;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic wr, input logic [ADDR_W-1:0] a,
                          input logic [15:0] d, input logic [1:0] be);
        int s_we, s_oe, s_ub, s_lb, s_any, s_rdy, s_rsp, s_bad;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        #1;
        s_we = we_low_n; s_oe = oe_low_n; s_ub = ub_low_n; s_lb = lb_low_n;
        s_any = any_n; s_rdy = rdy_low_n; s_rsp = rsp_n; s_bad = bad_n;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        #1;
        dl_we = we_low_n - s_we;   dl_oe = oe_low_n - s_oe;
        dl_ub = ub_low_n - s_ub;   dl_lb = lb_low_n - s_lb;
        dl_any = any_n - s_any;    dl_rdy = rdy_low_n - s_rdy;
        dl_rsp = rsp_n - s_rsp;    dl_bad = bad_n - s_bad;
        rd_val = last_rd;
        if (wr) begin
            if (be[0]) exp_mem[a[7:0]][7:0]  = d[7:0];
            if (be[1]) exp_mem[a[7:0]][15:8] = d[15:8];
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 ready", 32'(req_ready), 1);
        check("R1 cs_n", 32'(mem_cs_n), 1);
        check("R1 cs", 32'(mem_cs), 0);
        check("R1 oe_n", 32'(mem_oe_n), 1);
        check("R1 we_n", 32'(mem_we_n), 1);
        check("R1 lane selects", 32'({mem_ub_n, mem_lb_n}), 32'h3);
        check("R1 rsp_valid", 32'(rsp_valid), 0);
    endtask

    task automatic t_word_access;
        do_req(1'b1, 19'd5, 16'h1234, 2'b11);
        check("R5 we low cycles", dl_we, EXP_WAIT);
        check("R5 oe during write", dl_oe, 0);
        check("R8 write busy cycles", dl_rdy, EXP_WAIT + 2);
        check("R8 no rsp on write", dl_rsp, 0);
        check("R6 setup/recovery", dl_bad, 0);
        check("R10 wait is 7", dl_we, 7);
        do_req(1'b0, 19'd5, 16'h0, 2'b11);
        check("R2 word readback", rd_val, 16'h1234);
        check("R7 oe low cycles", dl_oe, EXP_WAIT);
        check("R7 no we in read", dl_we, 0);
        check("R8 one rsp", dl_rsp, 1);
        check("R8 read busy cycles", dl_rdy, EXP_WAIT + 2);
    endtask

    task automatic t_lane_write;
        do_req(1'b1, 19'd9, 16'hBEEF, 2'b01);
        check("R3 upper idle on lower write", dl_ub, 0);
        check("R3 lower select cycles", dl_lb, EXP_WAIT + 2);
        do_req(1'b0, 19'd9, 16'h0, 2'b11);
        check("R3 lower write readback", rd_val, exp_mem[9]);
        do_req(1'b1, 19'd10, 16'hC0DE, 2'b10);
        check("R3 lower idle on upper write", dl_lb, 0);
        do_req(1'b0, 19'd10, 16'h0, 2'b11);
        check("R3 upper write readback", rd_val, exp_mem[10]);
    endtask

    task automatic t_lane_read;
        do_req(1'b0, 19'd9, 16'h0, 2'b01);
        check("R4 lower read data", rd_val, {8'h00, exp_mem[9][7:0]});
        check("R4 upper select idle", dl_ub, 0);
        do_req(1'b0, 19'd10, 16'h0, 2'b10);
        check("R4 upper read data", rd_val, {exp_mem[10][15:8], 8'h00});
        check("R4 lower select idle", dl_lb, 0);
    endtask

    task automatic t_zero_be;
        do_req(1'b1, 19'd5, 16'hFFFF, 2'b00);
        check("R9 no strobes on write", dl_any, 0);
        check("R9 busy one cycle", dl_rdy, 1);
        do_req(1'b0, 19'd5, 16'h0, 2'b00);
        check("R9 no strobes on read", dl_any, 0);
        check("R9 rsp pulse", dl_rsp, 1);
        check("R9 zero data", rd_val, 16'h0);
        do_req(1'b0, 19'd5, 16'h0, 2'b11);
        check("R9 memory unchanged", rd_val, 16'h1234);
    endtask

    task automatic t_high_addr;
        do_req(1'b1, 19'h7FF03, 16'h5AA5, 2'b11);
        check("R2 full address on bus", last_sel_addr, 19'h7FF03);
        check("R6 setup/recovery high addr", dl_bad, 0);
        do_req(1'b0, 19'h7FF03, 16'h0, 2'b11);
        check("R2 high address readback", rd_val, 16'h5AA5);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) exp_mem[i] = init_word(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_word_access();
        t_lane_write();
        t_lane_read();
        t_zero_be();
        t_high_addr();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule